// File: doc/BRIEF.md
# Carry Resolver for Transform-Based Integer Multiplication

The block turns the coefficients that leave an inverse number-theoretic transform into the digits of the final product. Coefficient k carries weight 2^(b·k), so neighbouring coefficients overlap by 64 − b bits. Walking through them in order, the block adds each coefficient to a running carry of 64 − b + 1 bits. It keeps the low b bits as one output digit and passes the rest on as the new carry.

A beat carries r coefficients and yields r digits. The carry moves from the top lane of one beat into lane 0 of the next valid beat. A start marker on a beat clears the carry. A last marker makes the carry that remains after the beat appear as extra flush digits, next to that beat's digit group. Results appear two cycles after the input beat. Inside a beat, the carry-in is added to the beat's partial sum with a chunked generate/propagate lookahead, so the carry does not ripple lane by lane.

Top module: `carry_resolver`

## Requirements
- R1: Input lane i is `inCoefs[64i+63:64i]` and output lane i is `outDigits[24i+23:24i]` (defaults b = 24, r = 16). Output lane i equals the low b bits of (coefficient i + carry into lane i). The carry into lane i+1 is that sum shifted right by b.
- R2: The carry leaving lane r−1 of a valid beat enters lane 0 of the next valid beat, however many idle cycles lie between them.
- R3: On a valid beat with `inStart` high, the carry into lane 0 is zero.
- R4: `outValid` rises exactly two cycles after `inValid` is sampled high, once per beat. While `inValid` is low, `inStart`, `inLast` and `inCoefs` have no effect.
- R5: `outLast` is high, together with `outValid`, exactly for the result of a beat marked last. `outDigits` holds its value while `outValid` is low.
- R6: In the cycle that the result of a last beat appears, `flushValid` is high. `flushDigits` then holds the carry out of lane r−1, with flush digit j at bits [24j+23:24j]. `flushCount` gives the number of digits up to and including the highest non-zero one, and is 0 when the carry is zero. `flushValid` is low in every other cycle.
- R7: While the synchronous, active-high `rst` is sampled high, `outValid`, `outLast` and `flushValid` go low. A beat still in flight when reset is applied produces no output.
- R8: Coefficients at their maximum value (all ones) do not overflow. The remaining carry always fits in ⌈(64 − b + 1)/b⌉ flush digits (2 with the defaults).
- R9: A beat marked both start and last is resolved from a zero carry, and its carry is flushed with its own digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Coefficient group present this cycle |
| inStart | input | 1 | Group begins a new product (clears carry) |
| inLast | input | 1 | Group ends the product (flush carry) |
| inCoefs | input | LANES·COEF_W (1024) | r coefficients, lane i at bits [64i+63:64i] |
| outValid | output | 1 | Digit group present |
| outLast | output | 1 | Digit group belongs to a last beat |
| outDigits | output | LANES·DIGIT_W (384) | r digits, lane i at bits [24i+23:24i] |
| flushValid | output | 1 | Flush digits present |
| flushCount | output | 2 | Number of significant flush digits |
| flushDigits | output | 48 | Remaining carry as b-bit digits, lowest first |

## Verification
Two functions can coincide. Carry clearing and carry flushing land in one cycle when a single beat is marked both start and last. A job's last beat can also be followed immediately by the next job's start beat, so one job's flush and the next job's first digits come out on consecutive cycles with no gap. The bench provokes both with back-to-back beats, including all-ones coefficients that leave the largest carry. A software reference walks each coefficient one at a time with a 65-bit sum. It judges every digit group, the last flag, the flush digits and the flush count against that reference, independently of the grouped addition inside the block. Idle cycles are filled with asserted start/last markers and random coefficients, and the carry must pass through them unchanged.

// File: rtl/carry_res_pkg.sv
package carry_res_pkg;

  // Strobes from the control path into the datapath
  typedef struct packed {
    logic capture;    // stage-1 partial sum register loads
    logic advance;    // stage-2 resolves a group
    logic zeroCarry;  // group in stage 2 starts a product
    logic loadFlush;  // group in stage 2 ends a product
  } crStrobe_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/carry_res_ctrl.sv
module carry_res_ctrl
  import carry_res_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inStart,
  input  logic      inLast,
  output crStrobe_t strobe,
  output logic      outValid,
  output logic      outLast,
  output logic      flushValid
);

  logic stg1Valid;
  logic stg1Start;
  logic stg1Last;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1Valid  <= 1'b0;
      stg1Start  <= 1'b0;
      stg1Last   <= 1'b0;
      outValid   <= 1'b0;
      outLast    <= 1'b0;
      flushValid <= 1'b0;
    end else begin
      stg1Valid  <= inValid;
      stg1Start  <= inValid & inStart;
      stg1Last   <= inValid & inLast;
      outValid   <= stg1Valid;
      outLast    <= stg1Valid & stg1Last;
      flushValid <= stg1Valid & stg1Last;
    end
  end

  assign strobe.capture   = inValid;
  assign strobe.advance   = stg1Valid;
  assign strobe.zeroCarry = stg1Start;
  assign strobe.loadFlush = stg1Valid & stg1Last;

endmodule

// File: rtl/carry_res_dpath.sv
module carry_res_dpath
  import carry_res_pkg::*;
#(
  parameter  int DIGIT_W = 24,
  parameter  int LANES   = 16,
  parameter  int COEF_W  = 64,
  localparam int CAR_W   = COEF_W - DIGIT_W + 1,
  localparam int OUT_W   = LANES * DIGIT_W,
  localparam int FLUSH_N = cdiv(CAR_W, DIGIT_W),
  localparam int FW      = FLUSH_N * DIGIT_W,
  localparam int CNT_W   = $clog2(FLUSH_N + 1)
)(
  input  logic                    clk,
  input  logic                    rst,
  input  crStrobe_t               strobe,
  input  logic [LANES*COEF_W-1:0] inCoefs,
  output logic [OUT_W-1:0]        outDigits,
  output logic [FW-1:0]           flushDigits,
  output logic [CNT_W-1:0]        flushCount
);

  // Coefficients k and k+ROWS never overlap, so each row is a plain concatenation
  localparam int ROWS  = cdiv(COEF_W, DIGIT_W);
  localparam int PW    = DIGIT_W * (LANES - 1) + COEF_W + 1;
  localparam int NCH   = cdiv(PW, DIGIT_W);
  localparam int SW    = NCH * DIGIT_W;
  localparam int LASTW = PW - (NCH - 1) * DIGIT_W;

  // ---------------- stage 1: positional partial sum ----------------
  logic [PW-1:0] rowVec [ROWS];
  logic [PW-1:0] partSum;
  logic [PW-1:0] partReg;

  always_comb begin
    for (int j = 0; j < ROWS; j++) rowVec[j] = '0;
    for (int i = 0; i < LANES; i++)
      rowVec[i % ROWS][DIGIT_W*i +: COEF_W] = inCoefs[COEF_W*i +: COEF_W];
    partSum = '0;
    for (int j = 0; j < ROWS; j++) partSum = partSum + rowVec[j];
  end

  // ---------------- stage 2: carry-in add with chunk lookahead ----------------
  logic [CAR_W-1:0]   carryReg;
  logic [CAR_W-1:0]   carryIn;
  logic [SW-1:0]      partPad;
  logic [SW-1:0]      carPad;
  logic [DIGIT_W-1:0] chunkSum [NCH];
  logic [NCH-2:0]     chunkGen;
  logic [NCH-2:0]     chunkProp;
  logic [NCH-1:0]     chunkCin;
  logic [PW-1:0]      resSum;
  logic [OUT_W-1:0]   digitsNext;
  logic [CAR_W-1:0]   carryNext;
  logic [FW-1:0]      flushPad;
  logic [CNT_W-1:0]   cntNext;

  assign carryIn = strobe.zeroCarry ? '0 : carryReg;
  assign partPad = SW'(partReg);
  assign carPad  = SW'(carryIn);

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    if (c < NCH - 1) begin : g_mid
      logic [DIGIT_W:0] raw;
      assign raw          = {1'b0, partPad[c*DIGIT_W +: DIGIT_W]} + {1'b0, carPad[c*DIGIT_W +: DIGIT_W]};
      assign chunkSum[c]  = raw[DIGIT_W-1:0];
      assign chunkGen[c]  = raw[DIGIT_W];
      assign chunkProp[c] = &raw[DIGIT_W-1:0];
    end else begin : g_top
      assign chunkSum[c] = partPad[c*DIGIT_W +: DIGIT_W] + carPad[c*DIGIT_W +: DIGIT_W];
    end
  end

  // group carries from generate/propagate pairs
  always_comb begin
    logic cc;
    cc = 1'b0;
    for (int c = 0; c < NCH - 1; c++) begin
      chunkCin[c] = cc;
      cc = chunkGen[c] | (chunkProp[c] & cc);
    end
    chunkCin[NCH-1] = cc;
  end

  always_comb begin
    resSum = '0;
    for (int c = 0; c < NCH - 1; c++)
      resSum[c*DIGIT_W +: DIGIT_W] = chunkSum[c] + DIGIT_W'(chunkCin[c]);
    resSum[(NCH-1)*DIGIT_W +: LASTW] = chunkSum[NCH-1][LASTW-1:0] + LASTW'(chunkCin[NCH-1]);
  end

  assign digitsNext = resSum[OUT_W-1:0];
  assign carryNext  = resSum[OUT_W +: CAR_W];
  assign flushPad   = FW'(carryNext);

  always_comb begin
    cntNext = '0;
    for (int j = 0; j < FLUSH_N; j++)
      if (flushPad[j*DIGIT_W +: DIGIT_W] != '0) cntNext = CNT_W'(j + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      partReg     <= '0;
      carryReg    <= '0;
      outDigits   <= '0;
      flushDigits <= '0;
      flushCount  <= '0;
    end else begin
      if (strobe.capture) partReg <= partSum;
      if (strobe.advance) begin
        outDigits <= digitsNext;
        carryReg  <= carryNext;
      end
      if (strobe.loadFlush) begin
        flushDigits <= flushPad;
        flushCount  <= cntNext;
      end
    end
  end

endmodule

// File: rtl/carry_resolver.sv
module carry_resolver
  import carry_res_pkg::*;
#(
  parameter  int DIGIT_W = 24,
  parameter  int LANES   = 16,
  parameter  int COEF_W  = 64,
  localparam int CAR_W   = COEF_W - DIGIT_W + 1,
  localparam int FLUSH_N = cdiv(CAR_W, DIGIT_W),
  localparam int CNT_W   = $clog2(FLUSH_N + 1)
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  input  logic                      inStart,
  input  logic                      inLast,
  input  logic [LANES*COEF_W-1:0]   inCoefs,
  output logic                      outValid,
  output logic                      outLast,
  output logic [LANES*DIGIT_W-1:0]  outDigits,
  output logic                      flushValid,
  output logic [CNT_W-1:0]          flushCount,
  output logic [FLUSH_N*DIGIT_W-1:0] flushDigits
);

  crStrobe_t strobe;

  carry_res_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .inStart    (inStart),
    .inLast     (inLast),
    .strobe     (strobe),
    .outValid   (outValid),
    .outLast    (outLast),
    .flushValid (flushValid)
  );

  carry_res_dpath #(
    .DIGIT_W (DIGIT_W),
    .LANES   (LANES),
    .COEF_W  (COEF_W)
  ) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .inCoefs     (inCoefs),
    .outDigits   (outDigits),
    .flushDigits (flushDigits),
    .flushCount  (flushCount)
  );

endmodule

// File: rtl/carry_resolver_chk.sv
module carry_resolver_chk
  import carry_res_pkg::*;
#(
  parameter  int DIGIT_W = 24,
  parameter  int LANES   = 16,
  parameter  int COEF_W  = 64,
  localparam int CAR_W   = COEF_W - DIGIT_W + 1,
  localparam int FLUSH_N = cdiv(CAR_W, DIGIT_W),
  localparam int CNT_W   = $clog2(FLUSH_N + 1)
)(
  input logic                       clk,
  input logic                       rst,
  input logic                       inValid,
  input logic                       outValid,
  input logic                       outLast,
  input logic [LANES*DIGIT_W-1:0]   outDigits,
  input logic                       flushValid,
  input logic [CNT_W-1:0]           flushCount,
  input logic [FLUSH_N*DIGIT_W-1:0] flushDigits
);

  logic [1:0] sinceRst;
  logic       rstPrev;

  always_ff @(posedge clk) begin
    rstPrev <= rst;
    if (rst) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R4: a result follows each beat after exactly two cycles
  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2) |-> (outValid == $past(inValid, 2)));

  // R5: the last flag only travels with a digit group
  assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);

  // R5: digits hold while no group is presented
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ((sinceRst != 2'd0) && !outValid) |-> $stable(outDigits));

  // R6: flush appears only beside the last group of a product
  assert_flush_pair_R6: assert property (@(posedge clk) disable iff (rst)
    flushValid |-> (outValid && outLast));

  // R6: a zero count means the carry was zero, and the reverse
  assert_flush_count_R6: assert property (@(posedge clk) disable iff (rst)
    flushValid |-> ((flushCount == '0) == (flushDigits == '0)));

  // R8: the remaining carry never needs more than the flush lanes
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    flushValid |-> (flushCount <= CNT_W'(FLUSH_N)));

  // R7: outputs are quiet after a reset edge
  always @(negedge clk) begin
    if (rstPrev === 1'b1)
      assert_reset_R7: assert (!outValid && !outLast && !flushValid);
  end

endmodule

bind carry_resolver carry_resolver_chk #(
  .DIGIT_W (DIGIT_W),
  .LANES   (LANES),
  .COEF_W  (COEF_W)
) u_chk (.*);

// File: tb/sim_carry_resolver.sv
`timescale 1ns/1ps
module sim_carry_resolver;

  localparam int B    = 24;
  localparam int R    = 16;
  localparam int W    = 64;
  localparam int CW   = W - B + 1;
  localparam int FN   = (CW + B - 1) / B;
  localparam int CNTW = $clog2(FN + 1);
  localparam int DW   = R * B;

  // entry: [7] start, [6] last, [5:3] coefficient kind, [2:0] idle cycles before
  localparam logic [7:0] TBL [12] = '{
    8'b1_0_001_000,  // all ones, start           (R8)
    8'b0_0_001_000,  // all ones, back to back    (R2)
    8'b0_0_010_010,  // random after junk idles   (R4, R2)
    8'b0_1_010_000,  // random, last              (R6)
    8'b1_0_011_000,  // small, start right after last (R3)
    8'b0_1_100_001,  // alternating, last after an idle
    8'b1_0_001_000,  // all ones leaves large carry
    8'b1_1_001_000,  // start mid-job and last together (R3, R9)
    8'b1_1_000_000,  // all zero, flush count 0
    8'b1_0_010_011,  // random after three junk idles
    8'b0_1_001_000,  // all ones, last
    8'b1_1_101_000   // top lane only, flush count 1
  };

  typedef struct {
    logic [DW-1:0]   dig;
    logic            last;
    logic [FN*B-1:0] fl;
    logic [CNTW-1:0] cnt;
    string           tag;
  } exp_t;

  logic              clk;
  logic              rst;
  logic              inValid;
  logic              inStart;
  logic              inLast;
  logic [R*W-1:0]    inCoefs;
  logic              outValid;
  logic              outLast;
  logic [DW-1:0]     outDigits;
  logic              flushValid;
  logic [CNTW-1:0]   flushCount;
  logic [FN*B-1:0]   flushDigits;

  exp_t          expQ[$];
  exp_t          monE;
  int            nChk;
  int            nBad;
  logic [CW-1:0] mCarry;
  logic [63:0]   lcg;
  logic [DW-1:0] held;
  logic [7:0]    ent;

  carry_resolver #(.DIGIT_W(B), .LANES(R), .COEF_W(W)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inStart(inStart), .inLast(inLast),
    .inCoefs(inCoefs), .outValid(outValid), .outLast(outLast), .outDigits(outDigits),
    .flushValid(flushValid), .flushCount(flushCount), .flushDigits(flushDigits)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  function automatic logic [63:0] nextRand();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg ^ (lcg >> 29);
  endfunction

  function automatic logic [W-1:0] coefOf(input int kind, input int lane);
    case (kind)
      0: return '0;
      1: return '1;
      2: return nextRand();
      3: return W'(nextRand() & 64'hFF_FFFF);
      4: return (lane % 2 == 0) ? 64'hAAAA_AAAA_AAAA_AAAA : 64'h5555_5555_5555_5555;
      default: return (lane == R - 1) ? (64'h1 << 40) : '0;
    endcase
  endfunction

  // sequential reference: one coefficient at a time, 65-bit sum
  task automatic driveBeat(input bit st, input bit la, input int kind, input bit junk, input bit record);
    logic [R*W-1:0] co;
    logic [W:0]     s;
    exp_t           e;
    for (int i = 0; i < R; i++) co[i*W +: W] = coefOf(kind, i);
    if (st) mCarry = '0;
    for (int i = 0; i < R; i++) begin
      s = {1'b0, co[i*W +: W]} + (W+1)'(mCarry);
      e.dig[i*B +: B] = s[B-1:0];
      mCarry = s[W:B];
    end
    e.last = la;
    e.fl   = (FN*B)'(mCarry);
    e.cnt  = '0;
    for (int j = 0; j < FN; j++)
      if (e.fl[j*B +: B] != '0) e.cnt = CNTW'(j + 1);
    e.tag = {"R1", st ? " R3" : " R2", junk ? " R4" : "", (st && la) ? " R9" : "",
             (kind == 1) ? " R8" : ""};
    if (record) expQ.push_back(e);
    inValid = 1'b1; inStart = st; inLast = la; inCoefs = co;
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inLast = 1'b0;
  endtask

  task automatic idleJunk(input int n);
    for (int k = 0; k < n; k++) begin
      inValid = 1'b0; inStart = 1'b1; inLast = 1'b1;
      for (int i = 0; i < R; i++) inCoefs[i*W +: W] = nextRand();
      @(negedge clk);
    end
    inStart = 1'b0; inLast = 1'b0;
  endtask

  // monitor: compare every presented group against the reference queue
  always @(negedge clk) begin
    if (rst === 1'b0) begin
      if (outValid === 1'b1) begin
        if (expQ.size() == 0) chk(1'b0, "R4 output without a beat", DW'(outValid), '0);
        else begin
          monE = expQ.pop_front();
          chk(outDigits === monE.dig, {monE.tag, " digits"}, outDigits, monE.dig);
          chk(outLast === monE.last, "R5 last flag", DW'(outLast), DW'(monE.last));
          chk(flushValid === monE.last, "R6 flush valid", DW'(flushValid), DW'(monE.last));
          if (monE.last) begin
            chk(flushDigits === monE.fl, {"R6 flush digits", monE.tag}, DW'(flushDigits), DW'(monE.fl));
            chk(flushCount === monE.cnt, "R6 R8 flush count", DW'(flushCount), DW'(monE.cnt));
          end
        end
      end else if (flushValid !== 1'b0) begin
        chk(1'b0, "R6 flush without group", DW'(flushValid), '0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R4 watchdog: act=hung exp=finished");
    summary();
  end

  initial begin
    nChk = 0; nBad = 0; mCarry = '0; lcg = 64'h1234_5678_9ABC_DEF0;
    rst = 1'b1; inValid = 1'b0; inStart = 1'b0; inLast = 1'b0; inCoefs = '0;
    repeat (3) @(negedge clk);
    chk(outValid === 1'b0 && outLast === 1'b0 && flushValid === 1'b0, "R7 reset state",
        DW'({outValid, outLast, flushValid}), '0);
    rst = 1'b0;
    @(negedge clk);

    // latency and hold: one beat, start and last together
    driveBeat(1'b1, 1'b1, 3, 1'b0, 1'b1);
    chk(outValid === 1'b0, "R4 not after one cycle", DW'(outValid), '0);
    @(negedge clk);
    chk(outValid === 1'b1, "R4 after two cycles", DW'(outValid), 1);
    held = outDigits;
    @(negedge clk);
    chk(outValid === 1'b0, "R4 single result per beat", DW'(outValid), '0);
    chk(outDigits === held, "R5 digits held when idle", outDigits, held);

    // vector table
    for (int k = 0; k < 12; k++) begin
      ent = TBL[k];
      if (ent[2:0] != 3'd0) idleJunk(int'(ent[2:0]));
      driveBeat(ent[7], ent[6], int'(ent[5:3]), ent[2:0] != 3'd0, 1'b1);
    end
    repeat (6) @(negedge clk);
    chk(expQ.size() == 0, "R4 every beat answered", DW'(expQ.size()), '0);

    // reset while a beat is in flight
    driveBeat(1'b1, 1'b0, 1, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk(outValid === 1'b0 && flushValid === 1'b0, "R7 in-flight beat dropped", DW'(outValid), '0);
    @(negedge clk);
    chk(outValid === 1'b0, "R7 quiet during reset", DW'(outValid), '0);
    rst = 1'b0;
    @(negedge clk);
    chk(outValid === 1'b0, "R7 quiet after reset", DW'(outValid), '0);

    // recovery with a fresh product
    driveBeat(1'b1, 1'b1, 2, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R3 R7 recovery beat answered", DW'(expQ.size()), '0);

    summary();
  end

endmodule